// File: doc/BRIEF.md
# Multi-Register Load/Store Sequencer

This block carries out one block data transfer instruction: a single 32-bit instruction word that moves a whole set of registers to or from memory. The block holds a sixteen-entry, 32-bit register file. When it accepts an instruction it reads the start address from the chosen base register. It then walks the 16-bit register list from the lowest index to the highest and performs one word access on a simple valid/ready memory bus for each selected register. Loads write the returned word into the register file. Stores drive the register's value onto the bus.

Each instruction picks its own addressing. The address moves up or down by four bytes for every transfer, and the step is taken either before or after the access. At the end the final address can be written back into the base register. A one-cycle done pulse marks completion. While the block is idle, a plain write port and read port give access to the register file. Loading registers beforehand and reading results afterwards goes through these ports.

Top module: `mreg_xfer_seq`

## Requirements
- R1: An instruction is taken only when `start` is high, the block is idle, and instruction bits [27:25] equal 3'b100. Any other word presented with `start` is ignored: `busy`, `done` and `mem_valid` stay low.
- R2: Instruction fields are decoded as follows. Bits [15:0] are the register list, with bit i selecting register i. Bits [19:16] give the base register number. Bit 20 selects load (1) or store (0). Bit 21 requests write-back. Bit 23 selects up (1) or down (0). Bit 24 selects step-before-access (1) or step-after-access (0).
- R3: Exactly one bus access is made per set list bit, and the accesses go in ascending register index order.
- R4: The start address is the base register's value at acceptance. Every transfer moves the address by +4 when up and by -4 when down, wrapping modulo 2^32. With step-before, the access uses the stepped address. With step-after, the access uses the current address and the step follows.
- R5: A load writes `mem_rdata` into the selected register at the handshake and drives `mem_write` low. A store drives `mem_write` high with `mem_wdata` equal to the selected register's value.
- R6: Only one access is outstanding at a time. While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_wdata` and `mem_write` stay stable and `mem_valid` stays high.
- R7: With write-back, the base register receives the address after the last step. Without write-back, the base register is changed only if it is itself loaded.
- R8: An empty register list makes no bus access. `done` rises in the cycle right after acceptance, and write-back (when requested) stores the unchanged start address.
- R9: On a load with write-back where the base register is in the list, the write-back value overrides the loaded word. On a store where the base register is in the list, the stored word is the base register's value from before the instruction.
- R10: `done` is high for exactly one cycle: the cycle after the last handshake, or the cycle after acceptance when the list is empty. `busy` is high from the cycle after acceptance up to and including the `done` cycle.
- R11: The external register-file write port takes effect only while the block is idle. A write attempted while `busy` is high is ignored.
- R12: Bit 22 of the instruction has no effect on any access or register result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears the register file |
| start | input | 1 | Present `instr` for execution |
| instr | input | 32 | Instruction word |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_we | input | 1 | External register write enable (idle only) |
| rf_waddr | input | 4 | External register write index |
| rf_wdata | input | 32 | External register write data |
| rf_raddr | input | 4 | External register read index |
| rf_rdata | output | 32 | Combinational read data for `rf_raddr` |
| mem_valid | output | 1 | Bus access request |
| mem_write | output | 1 | 1 for a store, 0 for a load |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Bus accepts or completes the access this cycle |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |

## Verification
The bench covers all four step orders, with bus latencies from zero to three wait cycles. An off-by-one step, a swapped before/after choice or a wrong direction each shows up as a wrong first address. A design that dropped data under wait states would change the address while stalled or lose a transfer. The base register is placed inside the list for both loads and stores. A design that applied write-back before the loads would leave the loaded word in the base register, and one that stored the updated base would put the wrong word in memory. An empty list and a full list check that completion comes neither too early nor too late. A non-matching instruction class and a register write sent mid-instruction must both leave every register untouched.

// File: rtl/mreg_xfer_pkg.sv
package mreg_xfer_pkg;
  localparam int LIST_W = 16;
  localparam int BASE_W = $clog2(LIST_W);

  typedef struct packed {
    logic              pre;
    logic              up;
    logic              sbit;
    logic              wb;
    logic              load;
    logic [BASE_W-1:0] base;
    logic [LIST_W-1:0] list;
  } blk_fields_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_FIN} seq_state_t;

  // index of the lowest set bit (0 when none is set)
  function automatic logic [BASE_W-1:0] lowest_set(input logic [LIST_W-1:0] v);
    lowest_set = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = BASE_W'(i);
    end
  endfunction
endpackage

// File: rtl/mreg_decode.sv
module mreg_decode
  import mreg_xfer_pkg::*;
(
  input  logic [27:0]  word,
  output logic         is_blk,
  output blk_fields_t  fld
);
  // class test: the three top bits of the lookup index taken from word[27:20]
  assign is_blk   = (word[27:25] == 3'b100);
  assign fld.pre  = word[24];
  assign fld.up   = word[23];
  assign fld.sbit = word[22];
  assign fld.wb   = word[21];
  assign fld.load = word[20];
  assign fld.base = word[16 +: BASE_W];
  assign fld.list = word[LIST_W-1:0];
endmodule

// File: rtl/mreg_addr_step.sv
module mreg_addr_step #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] cur,
  input  logic            up,
  input  logic            pre,
  output logic [XLEN-1:0] acc,
  output logic [XLEN-1:0] nxt
);
  function automatic logic [XLEN-1:0] bump(input logic [XLEN-1:0] a, input logic up_i);
    bump = up_i ? a + XLEN'(STEP) : a - XLEN'(STEP);
  endfunction

  assign nxt = bump(cur, up);
  assign acc = pre ? nxt : cur;
endmodule

// File: rtl/mreg_regfile.sv
module mreg_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [IW-1:0]   ra_a,
  output logic [XLEN-1:0] rd_a,
  input  logic [IW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_b,
  input  logic [IW-1:0]   ra_c,
  output logic [XLEN-1:0] rd_c
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs_q[g] <= '0;
      else if (we && waddr == IW'(g))     regs_q[g] <= wdata;
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];
  assign rd_c = regs_q[ra_c];
endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq
  import mreg_xfer_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       instr,
  output logic              busy,
  output logic              done,
  input  logic              rf_we,
  input  logic [BASE_W-1:0] rf_waddr,
  input  logic [XLEN-1:0]   rf_wdata,
  input  logic [BASE_W-1:0] rf_raddr,
  output logic [XLEN-1:0]   rf_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ready,
  input  logic [XLEN-1:0]   mem_rdata
);
  localparam int NREG = LIST_W;

  seq_state_t        state_q;
  blk_fields_t       fld;
  logic              is_blk;
  logic              accept;
  logic [XLEN-1:0]   addr_q, acc_addr, nxt_addr, base_val, sel_val;
  logic [LIST_W-1:0] remain_q, remain_nxt;
  logic [BASE_W-1:0] cur_idx, base_q;
  logic              pre_q, up_q, wb_q, ld_q;
  logic              hs, more;
  logic              wr_en;
  logic [BASE_W-1:0] wr_idx;
  logic [XLEN-1:0]   wr_val;
  logic              unused_bits;

  assign unused_bits = ^{instr[31:28], fld.sbit};  // R12: S bit not consumed

  mreg_decode u_dec (.word(instr[27:0]), .is_blk(is_blk), .fld(fld));

  mreg_addr_step #(.XLEN(XLEN), .STEP(STEP)) u_step (
    .cur(addr_q), .up(up_q), .pre(pre_q), .acc(acc_addr), .nxt(nxt_addr)
  );

  mreg_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_idx), .wdata(wr_val),
    .ra_a(cur_idx), .rd_a(sel_val), .ra_b(fld.base), .rd_b(base_val),
    .ra_c(rf_raddr), .rd_c(rf_rdata)
  );

  // named events
  assign accept     = start && (state_q == SQ_IDLE) && is_blk;
  assign cur_idx    = lowest_set(remain_q);
  assign remain_nxt = remain_q & ~(LIST_W'(1) << cur_idx);
  assign hs         = mem_valid && mem_ready;
  assign more       = hs && (remain_nxt != '0);

  assign mem_valid = (state_q == SQ_XFER);
  assign mem_write = !ld_q;
  assign mem_addr  = acc_addr;
  assign mem_wdata = sel_val;
  assign busy      = (state_q != SQ_IDLE);
  assign done      = (state_q == SQ_FIN);

  // single register-file write port, owner chosen by state
  always_comb begin
    wr_en  = 1'b0;
    wr_idx = cur_idx;
    wr_val = mem_rdata;
    unique case (state_q)
      SQ_XFER: wr_en = hs && ld_q;
      SQ_FIN: begin
        wr_en  = wb_q;             // applied last: overrides a loaded base
        wr_idx = base_q;
        wr_val = addr_q;
      end
      SQ_IDLE: begin
        wr_en  = rf_we;
        wr_idx = rf_waddr;
        wr_val = rf_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      base_q   <= '0;
      pre_q    <= 1'b0;
      up_q     <= 1'b0;
      wb_q     <= 1'b0;
      ld_q     <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          addr_q   <= base_val;
          remain_q <= fld.list;
          base_q   <= fld.base;
          pre_q    <= fld.pre;
          up_q     <= fld.up;
          wb_q     <= fld.wb;
          ld_q     <= fld.load;
          state_q  <= (fld.list == '0) ? SQ_FIN : SQ_XFER;
        end
        SQ_XFER: if (hs) begin
          addr_q   <= nxt_addr;
          remain_q <= remain_nxt;
          if (remain_nxt == '0) state_q <= SQ_FIN;
        end
        SQ_FIN:  state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && instr[27:25] != 3'b100) |=> !busy);

  assert_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    more |=> (mem_valid && cur_idx > $past(cur_idx)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    more |=> (mem_addr == (up_q ? $past(mem_addr) + XLEN'(STEP)
                                : $past(mem_addr) - XLEN'(STEP))));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_wdata) && $stable(mem_write)));

  assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && instr[15:0] == 16'h0) |=> (done && !mem_valid));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/mreg_xfer_seq_test.sv
module mreg_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst_n, start, busy, done;
  logic [31:0] instr;
  logic        rf_we;
  logic [3:0]  rf_waddr, rf_raddr;
  logic [31:0] rf_wdata, rf_rdata;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  mreg_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy), .done(done),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] mem [256];
  logic [31:0] shadow [16];
  logic [31:0] log_addr [64];
  logic        log_wr   [64];
  logic [31:0] log_wd   [64];
  int log_n = 0, lat = 0, wcnt = 0;

  // memory model: answers at the negative edge
  always @(negedge clk) begin
    if (!rst_n || !mem_valid) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (wcnt >= lat) begin
      mem_ready = 1'b1;
      mem_rdata = mem[mem_addr[9:2]];
      if (log_n < 64) begin
        log_addr[log_n] = mem_addr; log_wr[log_n] = mem_write; log_wd[log_n] = mem_wdata;
      end
      log_n++;
      if (mem_write) mem[mem_addr[9:2]] = mem_wdata;
      wcnt = 0;
    end else begin
      mem_ready = 1'b0; wcnt++;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_reg(int i, logic [31:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 4'(i); rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    shadow[i] = v;
  endtask

  task automatic read_reg(int i, output logic [31:0] v);
    rf_raddr = 4'(i); #0.5; v = rf_rdata;
  endtask

  // one instruction, checked against a model built from the requirements
  task automatic run_blk(string tag, bit pre, bit up, bit sb, bit wb, bit ld,
                         int base, logic [15:0] list, int latency, bit poke);
    logic [31:0] e_addr [16];
    logic [31:0] e_wd   [16];
    logic [31:0] e_regs [16];
    logic [31:0] a, v;
    int e_n = 0, cyc = 0;
    for (int i = 0; i < 16; i++) e_regs[i] = shadow[i];
    a = shadow[base];
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        if (pre) a = up ? a + 32'd4 : a - 32'd4;
        e_addr[e_n] = a;
        e_wd[e_n]   = ld ? 32'h0 : shadow[i];
        if (ld) e_regs[i] = mem[a[9:2]];
        e_n++;
        if (!pre) a = up ? a + 32'd4 : a - 32'd4;
      end
    end
    if (wb) e_regs[base] = a;

    @(negedge clk);
    lat = latency; log_n = 0;
    instr = {4'hE, 3'b100, pre, up, sb, wb, ld, 4'(base), list};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk({tag, " R10"}, "busy after accept", {31'b0, busy}, 32'h1);
    while (!done && cyc < 500) begin
      if (poke && cyc == 0) begin
        rf_we = 1'b1; rf_waddr = 4'd9; rf_wdata = 32'hDEAD_0009;
      end
      @(negedge clk); #1;
      rf_we = 1'b0;
      cyc++;
    end
    chk({tag, " R10"}, "cycles to done", cyc, e_n * (latency + 1));
    chk({tag, " R10"}, "busy with done", {31'b0, busy}, 32'h1);
    @(negedge clk); #1;
    chk({tag, " R10"}, "done pulse width", {31'b0, done}, 32'h0);
    chk({tag, " R3"}, "access count", log_n, e_n);
    for (int k = 0; k < e_n && k < log_n; k++) begin
      chk({tag, " R4"}, "access address", log_addr[k], e_addr[k]);
      chk({tag, " R5"}, "access direction", {31'b0, log_wr[k]}, {31'b0, !ld});
      if (!ld) chk({tag, " R5"}, "store data", log_wd[k], e_wd[k]);
    end
    for (int i = 0; i < 16; i++) begin
      read_reg(i, v);
      chk({tag, (i == base) ? " R7" : " R5"}, $sformatf("r%0d", i), v, e_regs[i]);
      shadow[i] = e_regs[i];
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1;
    chk("R10", "busy after reset", {31'b0, busy}, 32'h0);
    chk("R10", "done after reset", {31'b0, done}, 32'h0);
    chk("R6", "valid after reset", {31'b0, mem_valid}, 32'h0);
    read_reg(7, v);
    chk("R5", "r7 after reset", v, 32'h0);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    @(negedge clk);
    log_n = 0;
    instr = {4'hE, 3'b101, 5'b11011, 4'd2, 16'h00FF};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 5; c++) begin
      #1;
      chk("R1", "busy on other class", {31'b0, busy}, 32'h0);
      chk("R1", "done on other class", {31'b0, done}, 32'h0);
      @(negedge clk);
    end
    chk("R1", "accesses on other class", log_n, 0);
    read_reg(2, v);
    chk("R1", "base untouched", v, shadow[2]);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0; rf_we = 1'b0; rf_waddr = '0;
    rf_wdata = '0; rf_raddr = '0; mem_ready = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 ^ (i * 32'h0101_0301);
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();

    for (int i = 0; i < 16; i++) set_reg(i, 32'h1111_0000 + i * 32'h0001_0101);
    // R2/R5: load, step after, up, write-back, with a mid-run poke (R11)
    set_reg(13, 32'h0000_0100);
    run_blk("LD-post-up R2 R11", 0, 1, 0, 1, 1, 13, 16'h00F5, 0, 1);
    chk("R11", "r9 after busy write", shadow[9], 32'h1111_0000 + 9 * 32'h0001_0101);
    // R12: store, step before, down, S bit set, wait states
    set_reg(12, 32'h0000_0200);
    run_blk("ST-pre-down R12", 1, 0, 1, 1, 0, 12, 16'h8421, 2, 0);
    // R7: load, step before, up, no write-back, base in list
    set_reg(3, 32'h0000_0040);
    run_blk("LD-pre-up nowb R7", 1, 1, 0, 0, 1, 3, 16'h0018, 0, 0);
    // R9: load, step after, down, write-back, base in list
    set_reg(5, 32'h0000_0300);
    run_blk("LD-post-down R9", 0, 0, 0, 1, 1, 5, 16'h00E0, 1, 0);
    // R9: store with base in list stores the old base value
    set_reg(1, 32'h0000_0080);
    run_blk("ST-base-in-list R9", 0, 1, 0, 1, 0, 1, 16'h0006, 3, 0);
    // R8: empty list
    set_reg(2, 32'h0000_0150);
    run_blk("empty-wb R8", 1, 1, 0, 1, 1, 2, 16'h0000, 0, 0);
    run_blk("empty-nowb R8", 0, 0, 0, 0, 0, 2, 16'h0000, 0, 0);
    // R3: full list
    set_reg(0, 32'h0000_0300);
    run_blk("ST-full R3", 1, 1, 0, 1, 0, 0, 16'hFFFF, 0, 0);
    t_reject();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule